// File: doc/BRIEF.md
# Parallel Port Handshake Interface

This block connects a processor bus to two byte-wide peripherals. One is a character source such as a key encoder, the other a character sink such as a printer. The processor sees three registers inside a four-word address window. The block decodes the window itself and finishes each bus cycle with a two-wire handshake: the master raises a request line and the block answers with an acknowledge line. All status bits change only as side effects of device strobes and processor accesses. Software never writes them directly.

On the input side, a strobe from the encoder latches the presented character into the input register and raises the input-full flag. A processor read of the input register clears that flag. If a second character arrives before the first was read, the new character replaces the old one and a sticky overrun bit is set. A status read clears the overrun bit.

On the output side, a processor write to the output register presents the character to the sink with a one-cycle valid pulse and clears the output-ready flag. The flag comes back once the sink signals idle in a cycle after that pulse.

Top module: `ppio_iface`

## Requirements
- R1: After a synchronous reset, `bus_srdy`, `bus_rdata`, `prn_valid` and `prn_data` are zero. The input-full flag and the overrun bit are 0, the output-ready flag is 1, and the input register reads 0.
- R2: An access whose address differs from `BASE_ADDR` in any bit above the two low bits gets no acknowledge and has no effect on the output or status state.
- R3: With a matching address, `bus_srdy` rises on the first clock edge after `bus_mrdy` is seen high. It stays high while `bus_mrdy` stays high and falls on the first edge after `bus_mrdy` is low. Each handshake performs exactly one access.
- R4: A cycle with `kbd_valid` high loads `kbd_char` into the input register and sets the input-full flag.
- R5: A read at offset 0 returns the input register on `bus_rdata`, which is valid while `bus_srdy` is high, and clears the input-full flag.
- R6: A strobe that arrives while the input-full flag is set, and with no offset-0 read in the same cycle, overwrites the input register and sets the overrun bit. The overrun bit stays set until a read at offset 2, and that read still returns the bit as set.
- R7: A write at offset 1 places the write data on `prn_data`, raises `prn_valid` for exactly one cycle and clears the output-ready flag.
- R8: The output-ready flag stays 0 while `prn_idle` is low. It returns to 1 on the first edge after the valid pulse at which `prn_idle` is high.
- R9: A read at offset 2 returns the status word: bit 0 is input-full, bit 1 is output-ready, bit 2 is overrun, and all higher bits are 0. Reads at offsets 1 and 3 return 0. Writes at offsets 0, 2 and 3 change no state.
- R10: If a strobe coincides with the edge of an offset-0 read, the read returns the previous character, the new character is kept, the input-full flag stays 1 and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Processor address |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | DATA_W | Processor write data |
| bus_mrdy | input | 1 | Master request, held until acknowledged |
| bus_rdata | output | DATA_W | Registered read data |
| bus_srdy | output | 1 | Slave acknowledge |
| kbd_valid | input | 1 | Input device strobe |
| kbd_char | input | DATA_W | Input device character |
| prn_data | output | DATA_W | Character presented to the output device |
| prn_valid | output | 1 | One-cycle output strobe |
| prn_idle | input | 1 | Output device ready for another character |

## Verification
The bench builds the block with an 8-bit data path, a 6-bit address and a base of 0x14. With a 6-bit address, near-miss addresses such as 0x11 and 0x35 can be built. Each of them shares the offset bits with a real register but differs in a single decoded bit, so a decoder that ignores any upper bit lets one of them through. The small word width still leaves status bits above bit 2 that must read as zero. It also lets the characters in the table cover all-ones, all-zeros and alternating patterns.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int OFS_W = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_DIN  = 2'd0,
    OFS_DOUT = 2'd1,
    OFS_STAT = 2'd2,
    OFS_RSVD = 2'd3
  } reg_ofs_e;

  localparam int STAT_SIN  = 0;
  localparam int STAT_SOUT = 1;
  localparam int STAT_OVR  = 2;
  localparam int STAT_BITS = 3;
endpackage

// File: rtl/ppio_bus_ctl.sv
module ppio_bus_ctl
  import ppio_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mrdy,
  output logic              srdy,
  output logic              acc,
  output reg_ofs_e          ofs
);
  localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);
  localparam int                TAG_W    = ADDR_W - OFS_W;

  logic hit;
  logic srdy_q;

  assign hit  = (addr[ADDR_W-1:OFS_W] == BASE_VEC[ADDR_W-1:OFS_W]);
  assign ofs  = reg_ofs_e'(addr[OFS_W-1:0]);
  // A new access begins only on the first request cycle before the acknowledge
  assign acc  = mrdy && hit && !srdy_q;
  assign srdy = srdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      srdy_q <= 1'b0;
    end else if (!mrdy) begin
      srdy_q <= 1'b0;
    end else if (acc) begin
      srdy_q <= 1'b1;
    end
  end

  if (TAG_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed the offset width");
  end
endmodule

// File: rtl/ppio_in_chan.sv
module ppio_in_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] char_in,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] din,
  output logic              full,
  output logic              ovr
);
  logic [DATA_W-1:0] din_q;
  logic              full_q;
  logic              ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (strobe) begin
        din_q <= char_in;
      end
      // a fresh character wins over the clearing read
      if (strobe) begin
        full_q <= 1'b1;
      end else if (rd_data) begin
        full_q <= 1'b0;
      end
      // overrun only if the old character was never consumed
      if (strobe && full_q && !rd_data) begin
        ovr_q <= 1'b1;
      end else if (rd_stat) begin
        ovr_q <= 1'b0;
      end
    end
  end

  assign din  = din_q;
  assign full = full_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/ppio_out_chan.sv
module ppio_out_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dev_idle,
  output logic [DATA_W-1:0] dev_data,
  output logic              dev_valid,
  output logic              ready
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      valid_q <= wr_en;
      if (wr_en) begin
        data_q  <= wr_data;
        ready_q <= 1'b0;
      end else if (!ready_q && !valid_q && dev_idle) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign dev_data  = data_q;
  assign dev_valid = valid_q;
  assign ready     = ready_q;
endmodule

// File: rtl/ppio_iface.sv
module ppio_iface
  import ppio_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rnw,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_mrdy,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_srdy,
  input  logic              kbd_valid,
  input  logic [DATA_W-1:0] kbd_char,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_valid,
  input  logic              prn_idle
);
  logic              acc;
  reg_ofs_e          ofs;
  logic              rd_din;
  logic              rd_stat;
  logic              wr_dout;
  logic [DATA_W-1:0] din_q;
  logic              sin_q;
  logic              sout_q;
  logic              ovr_q;
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] rdata_q;

  ppio_bus_ctl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_bus (
    .clk (clk),
    .rst (rst),
    .addr(bus_addr),
    .mrdy(bus_mrdy),
    .srdy(bus_srdy),
    .acc (acc),
    .ofs (ofs)
  );

  assign rd_din  = acc &&  bus_rnw && (ofs == OFS_DIN);
  assign rd_stat = acc &&  bus_rnw && (ofs == OFS_STAT);
  assign wr_dout = acc && !bus_rnw && (ofs == OFS_DOUT);

  ppio_in_chan #(.DATA_W(DATA_W)) u_in (
    .clk    (clk),
    .rst    (rst),
    .strobe (kbd_valid),
    .char_in(kbd_char),
    .rd_data(rd_din),
    .rd_stat(rd_stat),
    .din    (din_q),
    .full   (sin_q),
    .ovr    (ovr_q)
  );

  ppio_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_dout),
    .wr_data  (bus_wdata),
    .dev_idle (prn_idle),
    .dev_data (prn_data),
    .dev_valid(prn_valid),
    .ready    (sout_q)
  );

  always_comb begin
    stat_w            = '0;
    stat_w[STAT_SIN]  = sin_q;
    stat_w[STAT_SOUT] = sout_q;
    stat_w[STAT_OVR]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (acc && bus_rnw) begin
      unique case (ofs)
        OFS_DIN:  rdata_q <= din_q;
        OFS_STAT: rdata_q <= stat_w;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  if (DATA_W < STAT_BITS) begin : g_bad_data
    initial $error("DATA_W too small for the status word");
  end
endmodule

// File: rtl/ppio_iface_chk.sv
module ppio_iface_chk #(
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32'h40
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rnw,
  input logic              bus_mrdy,
  input logic              bus_srdy,
  input logic              kbd_valid,
  input logic              prn_valid,
  input logic              sin,
  input logic              sout,
  input logic              ovr
);
  localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);

  logic in_win;
  logic din_rd;
  assign in_win = (bus_addr[ADDR_W-1:2] == BASE_VEC[ADDR_W-1:2]);
  assign din_rd = bus_mrdy && !bus_srdy && in_win && bus_rnw && (bus_addr[1:0] == 2'd0);

  // R3
  srdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_srdy) |-> $past(bus_mrdy && in_win));
  // R3
  srdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_srdy && bus_mrdy) |=> bus_srdy);
  // R3
  srdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_mrdy |=> !bus_srdy);
  // R4
  sin_set_chk: assert property (@(posedge clk) disable iff (rst)
    kbd_valid |=> sin);
  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (kbd_valid && sin && !din_rd) |=> ovr);
  // R7
  prn_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    prn_valid |=> !prn_valid);
  // R7
  prn_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prn_valid) |-> $past(bus_mrdy && !bus_srdy && !bus_rnw && in_win));
  // R8
  sout_low_chk: assert property (@(posedge clk) disable iff (rst)
    prn_valid |-> !sout);
endmodule

bind ppio_iface ppio_iface_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_rnw  (bus_rnw),
  .bus_mrdy (bus_mrdy),
  .bus_srdy (bus_srdy),
  .kbd_valid(kbd_valid),
  .prn_valid(prn_valid),
  .sin      (sin_q),
  .sout     (sout_q),
  .ovr      (ovr_q)
);

// File: tb/test_ppio_iface.sv
module test_ppio_iface;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int unsigned BASE = 32'h14;
  localparam logic [AW-1:0] A_DIN  = 6'h14;
  localparam logic [AW-1:0] A_DOUT = 6'h15;
  localparam logic [AW-1:0] A_STAT = 6'h16;
  localparam logic [AW-1:0] A_RSVD = 6'h17;
  localparam int NVEC = 5;
  // {input character, output character}
  localparam logic [15:0] VEC [NVEC] = '{16'hA55A, 16'h0FF0, 16'hFF00, 16'h00FF, 16'h3C81};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rnw = 1'b1;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_mrdy = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          bus_srdy;
  logic          kbd_valid = 1'b0;
  logic [DW-1:0] kbd_char = '0;
  logic [DW-1:0] prn_data;
  logic          prn_valid;
  logic          prn_idle = 1'b1;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  int run = 0;
  int max_run = 0;
  logic [DW-1:0] last_prn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppio_iface #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) i_ppio_iface (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
    .bus_wdata(bus_wdata), .bus_mrdy(bus_mrdy), .bus_rdata(bus_rdata),
    .bus_srdy(bus_srdy), .kbd_valid(kbd_valid), .kbd_char(kbd_char),
    .prn_data(prn_data), .prn_valid(prn_valid), .prn_idle(prn_idle)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (prn_valid) begin
        pulses   = pulses + 1;
        last_prn = prn_data;
        run      = run + 1;
        if (run > max_run) max_run = run;
      end else begin
        run = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic rnw, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    bus_addr = a; bus_rnw = rnw; bus_wdata = wd; bus_mrdy = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_srdy && lat < 8);
    rd = bus_rdata;
    bus_mrdy = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] rd);
    int lat;
    xfer(a, 1'b1, '0, rd, lat);
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] wd);
    logic [DW-1:0] dummy;
    int lat;
    xfer(a, 1'b0, wd, dummy, lat);
  endtask

  task automatic kbd_pulse(input logic [DW-1:0] ch);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_char = ch;
    @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] rd;
    int lat;
    int p0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 srdy", bus_srdy, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 prn_valid", prn_valid, 0);
    chk("R1 prn_data", prn_data, 0);
    rd_reg(A_STAT, rd); chk("R1 status", rd, 8'h02);
    rd_reg(A_DIN, rd);  chk("R1 datain", rd, 8'h00);

    // table walk: R4 R5 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      kbd_pulse(VEC[i][15:8]);
      rd_reg(A_STAT, rd); chk("R4 full set", rd, 8'h03);
      rd_reg(A_DIN, rd);  chk("R5 datain", rd, {24'd0, VEC[i][15:8]});
      rd_reg(A_STAT, rd); chk("R5 full clr", rd, 8'h02);
      p0 = pulses;
      wr_reg(A_DOUT, VEC[i][7:0]);
      repeat (2) @(negedge clk);
      chk("R7 one pulse", pulses, p0 + 1);
      chk("R7 prn_data", last_prn, {24'd0, VEC[i][7:0]});
      rd_reg(A_STAT, rd); chk("R8 ready back", rd, 8'h02);
    end
    chk("R7 pulse width", max_run, 1);

    // R3 handshake timing
    @(negedge clk);
    bus_addr = A_STAT; bus_rnw = 1'b1; bus_mrdy = 1'b1;
    @(negedge clk); chk("R3 ack one edge", bus_srdy, 1);
    repeat (3) @(negedge clk);
    chk("R3 ack held", bus_srdy, 1);
    bus_mrdy = 1'b0;
    @(negedge clk); chk("R3 ack drops", bus_srdy, 0);
    xfer(A_DIN, 1'b1, '0, rd, lat); chk("R3 latency", lat, 1);

    // R8 ready held low while sink busy
    prn_idle = 1'b0;
    wr_reg(A_DOUT, 8'hC3);
    repeat (4) @(negedge clk);
    rd_reg(A_STAT, rd); chk("R8 busy", rd, 8'h00);
    prn_idle = 1'b1;
    repeat (2) @(negedge clk);
    rd_reg(A_STAT, rd); chk("R8 idle", rd, 8'h02);

    // R2 near-miss addresses
    p0 = pulses;
    @(negedge clk);
    bus_addr = 6'h11; bus_rnw = 1'b0; bus_wdata = 8'h99; bus_mrdy = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 no ack low tag", bus_srdy, 0);
    bus_addr = 6'h35; bus_rnw = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 no ack high tag", bus_srdy, 0);
    bus_mrdy = 1'b0;
    @(negedge clk);
    chk("R2 no pulse", pulses, p0);
    chk("R2 prn_data kept", prn_data, 8'hC3);
    rd_reg(A_STAT, rd); chk("R2 status kept", rd, 8'h02);

    // R6 overrun
    kbd_pulse(8'h11);
    kbd_pulse(8'h22);
    rd_reg(A_STAT, rd); chk("R6 overrun seen", rd, 8'h07);
    rd_reg(A_STAT, rd); chk("R6 overrun cleared", rd, 8'h03);
    rd_reg(A_DIN, rd);  chk("R6 overwritten", rd, 8'h22);
    rd_reg(A_STAT, rd); chk("R6 empty", rd, 8'h02);

    // R10 strobe coincident with data read
    kbd_pulse(8'h33);
    @(negedge clk);
    bus_addr = A_DIN; bus_rnw = 1'b1; bus_mrdy = 1'b1;
    kbd_valid = 1'b1; kbd_char = 8'h5A;
    @(negedge clk);
    kbd_valid = 1'b0;
    chk("R10 ack", bus_srdy, 1);
    chk("R10 old char", bus_rdata, 8'h33);
    bus_mrdy = 1'b0;
    @(negedge clk);
    rd_reg(A_STAT, rd); chk("R10 full no ovr", rd, 8'h03);
    rd_reg(A_DIN, rd);  chk("R10 new char", rd, 8'h5A);

    // R9 unused offsets and ignored writes
    rd_reg(A_DOUT, rd); chk("R9 dout reads 0", rd, 8'h00);
    rd_reg(A_RSVD, rd); chk("R9 rsvd reads 0", rd, 8'h00);
    wr_reg(A_DIN, 8'hFF);
    rd_reg(A_DIN, rd);  chk("R9 din write ignored", rd, 8'h5A);
    p0 = pulses;
    wr_reg(A_STAT, 8'h00);
    wr_reg(A_RSVD, 8'hAA);
    rd_reg(A_STAT, rd); chk("R9 status write ignored", rd, 8'h02);
    chk("R9 no pulse", pulses, p0);
    chk("R9 prn_data kept", prn_data, 8'hC3);

    summary();
  end
endmodule